// File: doc/BRIEF.md
# Prescaled Shared Period Counter

This block is the common timebase behind a group of PWM channels. A single up-counter advances once every 2^PS input clocks, where PS is a programmable power-of-two prescale. It wraps to zero after reaching a programmable modulo value. Each channel unit compares against the shared count and restarts its cycle on the one-clock reload strobe, so every channel runs with the same period.

Software controls the block through a small word-addressed register port. There are four registers: a control word holding the prescale and clock-mode fields, a count register that can be read or cleared, a modulo register, and a read-only parameter word that reports how many channels share the timebase. The modulo value is double-buffered. A write lands at once while the counter is stopped, but waits for the next reload while the counter runs, so a period never ends mid-cycle. The prescale is frozen while the counter runs.

Top module: `shared_timebase`

## Requirements
- R1: After reset the count is 0, reload is 0, the control word (offset 0x10) reads 0, and the modulo register (offset 0x18) reads 0xFFFF.
- R2: With clock mode (control bits [4:3]) equal to 01 and prescale (control bits [2:0]) equal to PS, the count advances by one every 2^PS clocks.
- R3: On the prescaled tick where the count equals the modulo value, the count returns to 0 and reload is high for that one clock. Consecutive reloads are therefore (modulo+1)*2^PS clocks apart.
- R4: A write to the prescale field is ignored unless clock mode was 00 before the write; the control word then still reads the old prescale.
- R5: With clock mode 00 the count holds its value and reload stays low.
- R6: While clock mode is 00, a modulo write takes effect at once and reads back from offset 0x18 immediately.
- R7: While clock mode is nonzero, a modulo write is buffered. Offset 0x18 keeps showing the active value until the next reload, when the buffered value is loaded and governs the following period.
- R8: Any write to the count register (offset 0x14) clears the count to 0 and restarts the prescaler, so the next increment comes a full 2^PS clocks later.
- R9: Control bit 5 (center-aligned select) always reads 0, and writing it has no effect.
- R10: The parameter word at offset 0x04 returns the channel count in bits [7:0].
- R11: With modulo 0xFFFF the period is 65536 prescaled ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| count | output | CNT_W | Current shared count |
| reload | output | 1 | One-clock pulse when the count wraps to 0 |

## Verification
The bench keeps the default 16-bit count and 3-bit prescale, so the full 65536-tick period at prescale 0 is run end to end, alongside short periods with moduli of 0, 3 and 7. It overrides the channel count to 4, so the parameter word is shown to follow the parameter rather than a fixed constant. A prescale of 2 makes the divider visible: the four-clock gap after a count clear, and a modulo change taking effect at a reload.

// File: rtl/shared_timebase.sv
module shared_timebase #(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int NCHAN  = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              reload
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_MOD   = ADDR_W'('h18);

  logic [PS_W-1:0]  ps;
  logic [1:0]       cmod;
  logic [CNT_W-1:0] mod_act, mod_buf;
  logic [DIV_W-1:0] div, div_lim;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_cnt  = wr_en && addr == A_CNT;
  wire wr_mod  = wr_en && addr == A_MOD;
  wire stopped = cmod == 2'b00;
  wire run     = cmod == 2'b01;

  assign div_lim = (DIV_W'(1) << ps) - DIV_W'(1);
  wire tick = run && div == div_lim;
  wire wrap = tick && count == mod_act;

  wire unused_wbits = &{1'b0, wdata[DATA_W-1:CNT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps      <= '0;
      cmod    <= 2'b00;
      div     <= '0;
      count   <= '0;
      reload  <= 1'b0;
      mod_act <= '1;
      mod_buf <= '1;
    end else begin
      if (wr_ctrl) begin
        cmod <= wdata[4:3];
        if (stopped) ps <= wdata[PS_W-1:0];
      end

      if (wr_cnt)      div <= '0;
      else if (tick)   div <= '0;
      else if (run)    div <= div + DIV_W'(1);

      if (wr_cnt)      count <= '0;
      else if (wrap)   count <= '0;
      else if (tick)   count <= count + CNT_W'(1);

      reload <= wrap && !wr_cnt;

      if (wr_mod) mod_buf <= wdata[CNT_W-1:0];
      if (wr_mod && stopped) mod_act <= wdata[CNT_W-1:0];
      else if (wrap)         mod_act <= mod_buf;
    end
  end

  always_comb begin
    case (addr)
      A_PARAM: rdata = DATA_W'(8'(NCHAN));
      A_CTRL:  rdata = DATA_W'({1'b0, cmod, 3'(ps)});
      A_CNT:   rdata = DATA_W'(count);
      A_MOD:   rdata = DATA_W'(mod_act);
      default: rdata = '0;
    endcase
  end
endmodule

module shared_timebase_chk #(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  count,
  input logic              reload,
  input logic [1:0]        cmod,
  input logic [PS_W-1:0]   ps,
  input logic [CNT_W-1:0]  mod_act
);
  wire cnt_wr = wr_en && addr == ADDR_W'('h14);

  // R3
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> count == '0);

  // R5
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmod == 2'b00 && !cnt_wr) |=> ($stable(count) && !reload));

  // R4
  ps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmod != 2'b00) |=> $stable(ps));

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == '0);

  // R7
  mod_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_act) |-> ($past(cmod) == 2'b00 || reload));
endmodule

bind shared_timebase shared_timebase_chk #(
  .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .count(count),
  .reload(reload), .cmod(cmod), .ps(ps), .mod_act(mod_act)
);

// File: tb/shared_timebase_tb.sv
module shared_timebase_tb_top;
  localparam int CNT_W = 16, ADDR_W = 8, DATA_W = 32, NCH = 4;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [CNT_W-1:0]  count;
  logic              reload;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  shared_timebase #(.CNT_W(CNT_W), .PS_W(3), .NCHAN(NCH),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count(count), .reload(reload));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_reload(output int t);
    do @(negedge clk); while (!reload);
    t = cyc;
  endtask

  task automatic period(input string req, input int exp);
    int t0, t1;
    wait_reload(t0);
    chk(count == 0, "R3 count at reload", count, 0);
    wait_reload(t1);
    chk(t1 - t0 == exp, req, t1 - t0, exp);
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    chk(count == 0, "R1 count", count, 0);
    chk(reload == 0, "R1 reload", reload, 0);
    rd('h10, d); chk(d == 0, "R1 ctrl", d, 0);
    rd('h18, d); chk(d == 'hFFFF, "R1 modulo", d, 'hFFFF);
    rd('h04, d); chk(d[7:0] == NCH, "R10 channel count", d[7:0], NCH);
  endtask

  task automatic t_basic;
    logic [DATA_W-1:0] d;
    wr('h18, 3);
    rd('h18, d); chk(d == 3, "R6 immediate modulo", d, 3);
    wr('h10, 'h08);
    period("R2 R3 ps0 mod3 period", 4);
  endtask

  task automatic t_modzero;
    wr('h10, 'h00); wr('h10, 'h01); wr('h18, 0); wr('h14, 0);
    wr('h10, 'h09);
    period("R3 ps1 mod0 period", 2);
  endtask

  task automatic t_prescale;
    logic [DATA_W-1:0] d;
    wr('h10, 'h00); wr('h10, 'h02); wr('h18, 3); wr('h14, 0);
    wr('h10, 'h0A);
    period("R2 ps2 mod3 period", 16);
    wr('h10, 'h0D);
    rd('h10, d); chk(d[2:0] == 2, "R4 ps ignored while running", d[2:0], 2);
  endtask

  task automatic t_clear;
    wr('h14, 0);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk); chk(count == 0, "R8 held after clear", count, 0);
    end
    @(negedge clk); chk(count == 1, "R8 first step after 4 clocks", count, 1);
  endtask

  task automatic t_buffered;
    logic [DATA_W-1:0] d;
    int t0, t1;
    wait_reload(t0);
    wr('h18, 7);
    rd('h18, d); chk(d == 3, "R7 active kept before reload", d, 3);
    wait_reload(t0);
    rd('h18, d); chk(d == 7, "R7 loaded at reload", d, 7);
    wait_reload(t1);
    chk(t1 - t0 == 32, "R7 new period", t1 - t0, 32);
  endtask

  task automatic t_stop;
    logic [CNT_W-1:0] c0;
    logic [DATA_W-1:0] d;
    bit seen = 0;
    wr('h10, 'h02);
    c0 = count;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (reload) seen = 1;
    end
    chk(count == c0, "R5 count held", count, c0);
    chk(!seen, "R5 no reload while stopped", seen, 0);
    wr('h10, 'h20);
    rd('h10, d); chk(d[5] == 0, "R9 center bit reads 0", d[5], 0);
    chk(d[2:0] == 0, "R4 ps written while stopped", d[2:0], 0);
  endtask

  task automatic t_max;
    wr('h10, 'h00); wr('h18, 'hFFFF); wr('h14, 0);
    wr('h10, 'h08);
    period("R11 full period", 65536);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_basic; t_modzero; t_prescale; t_clear; t_buffered; t_stop; t_max;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule